// File: doc/BRIEF.md
# Memory-mapped two-operand adder with AXI-Lite register access

This block is an AXI-Lite slave with a 32-bit data path that gives a host a tiny arithmetic service. The host stores two unsigned operands in writable registers and writes a one into the start bit of a control register. The block then forms the unsigned sum and its carry-out, keeps both in read-only registers, and raises a ready flag in the control register.

The host polls that flag and then fetches the sum and the carry. Once both result registers have been read, in either order, the flag drops without any further write.

A five-state machine runs the bus side. It accepts the write address and the write data in the same cycle or in either order. It gives writes precedence over reads and serves one transaction at a time.

Register offsets (byte addresses, compared over the full address width):

| Offset | Name | Access |
|---|---|---|
| 0x00 | first operand | read/write |
| 0x04 | second operand | read/write |
| 0x08 | sum | read-only |
| 0x0C | carry (bit 0) | read-only |
| 0x10 | control: bit 0 start, bit 1 ready | mixed |

Top module: `axil_adder`

## Requirements
- R1: A write to offset 0x00 or 0x04 stores all 32 data bits, and a later read of the same offset returns them unchanged.
- R2: Writing the control register at 0x10 with bit 0 set computes {carry, sum} = first operand + second operand as unsigned numbers. The sum reads at 0x08. The carry reads at 0x0C in bit 0, with bits 31:1 of that register always zero.
- R3: A read of the control register returns the ready flag in bit 1 and zero in every other bit, including the start bit 0. A control write with bit 0 clear starts nothing.
- R4: The ready flag is set when a new result is stored. It stays set while only one of sum and carry has been read since then. It clears once both have been read, in either order.
- R5: Writes to offsets 0x08, 0x0C or any unmapped address change no register.
- R6: A read of any address other than the five offsets, including unaligned ones, returns 0xDEADBEEF.
- R7: The write address and write data may be accepted in the same cycle or in either order. Each write produces exactly one write response, with bresp equal to 2'b00.
- R8: bvalid stays high until bready. rvalid stays high until rready, with rdata held constant meanwhile. rresp is 2'b00.
- R9: While awvalid or wvalid is high in the idle state, arready is low. A pending write is therefore served before a simultaneous read, and the read then returns the newly written value.
- R10: After the synchronous active-high reset, every register reads zero, bvalid and rvalid are low, and awready, wready and arready are high.
- R11: No ready output is high while a write response or read data is pending. bvalid and rvalid are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | ADDR_W | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | DATA_W | Write data |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response code |

## Verification
The bench feeds operand pairs that carry out of bit 31 and pairs that do not. A design that dropped the carry or sign-extended would show the wrong carry or sum. Sum and carry are read in both orders, with the flag probed after the first read. A flag that cleared on a single read, or only on one fixed order, is caught there. Writes arrive address-first, data-first and together, and a write and a read are raised in the same cycle. A machine that lost a channel would hang, and one that let the read pass would return the stale value. Writes to read-only and unmapped offsets, and unaligned reads, expose a decoder that masks low address bits or lets a write reach the results.

// File: rtl/axadd_pkg.sv
package axadd_pkg;

    localparam int REG_W = 32;
    localparam int OFS_W = 8;

    localparam logic [31:0] OFS_OPA  = 32'h00;
    localparam logic [31:0] OFS_OPB  = 32'h04;
    localparam logic [31:0] OFS_SUM  = 32'h08;
    localparam logic [31:0] OFS_COUT = 32'h0C;
    localparam logic [31:0] OFS_CTRL = 32'h10;
    localparam logic [31:0] MISS_VALUE = 32'hDEAD_BEEF;

    localparam int CTRL_GO_BIT  = 0;
    localparam int CTRL_RDY_BIT = 1;

    typedef enum logic [2:0] {
        BUS_IDLE  = 3'd0,
        BUS_WAIT  = 3'd1,
        BUS_WRITE = 3'd2,
        BUS_BRESP = 3'd3,
        BUS_READ  = 3'd4
    } bus_state_e;

    typedef struct packed {
        logic opa;
        logic opb;
        logic sum;
        logic cout;
        logic ctrl;
    } reg_sel_t;

    function automatic reg_sel_t decode_ofs(input logic [31:0] ofs);
        reg_sel_t s;
        s.opa  = (ofs == OFS_OPA);
        s.opb  = (ofs == OFS_OPB);
        s.sum  = (ofs == OFS_SUM);
        s.cout = (ofs == OFS_COUT);
        s.ctrl = (ofs == OFS_CTRL);
        return s;
    endfunction

endpackage

// File: rtl/axadd_bus_fsm.sv
module axadd_bus_fsm
    import axadd_pkg::*;
#(
    parameter int ADDR_W = OFS_W,
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    output logic              bvalid,
    input  logic              bready,
    input  logic              arvalid,
    output logic              arready,
    input  logic [ADDR_W-1:0] araddr,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_value
);

    bus_state_e state_q, state_d;
    logic aw_got_q, w_got_q;
    logic aw_hs, w_hs, ar_hs;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q, rdata_q;

    always_comb begin
        awready = (state_q == BUS_IDLE) || (state_q == BUS_WAIT && !aw_got_q);
        wready  = (state_q == BUS_IDLE) || (state_q == BUS_WAIT && !w_got_q);
        arready = (state_q == BUS_IDLE) && !awvalid && !wvalid;
    end

    assign aw_hs = awvalid && awready;
    assign w_hs  = wvalid && wready;
    assign ar_hs = arvalid && arready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (aw_hs && w_hs)      state_d = BUS_WRITE;
                else if (aw_hs || w_hs) state_d = BUS_WAIT;
                else if (ar_hs)         state_d = BUS_READ;
            end
            BUS_WAIT:  if (aw_hs || w_hs) state_d = BUS_WRITE;
            BUS_WRITE: state_d = BUS_BRESP;
            BUS_BRESP: if (bready) state_d = BUS_IDLE;
            BUS_READ:  if (rready) state_d = BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= BUS_IDLE;
            aw_got_q <= 1'b0;
            w_got_q  <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
            rdata_q  <= '0;
        end else begin
            state_q <= state_d;
            if (aw_hs) begin
                addr_q   <= awaddr;
                aw_got_q <= 1'b1;
            end else if (state_q == BUS_WRITE) begin
                aw_got_q <= 1'b0;
            end
            if (w_hs) begin
                data_q  <= wdata;
                w_got_q <= 1'b1;
            end else if (state_q == BUS_WRITE) begin
                w_got_q <= 1'b0;
            end
            if (ar_hs) rdata_q <= rd_value;
        end
    end

    assign bvalid  = (state_q == BUS_BRESP);
    assign rvalid  = (state_q == BUS_READ);
    assign rdata   = rdata_q;
    assign wr_en   = (state_q == BUS_WRITE);
    assign wr_addr = addr_q;
    assign wr_data = data_q;
    assign rd_en   = ar_hs;
    assign rd_addr = araddr;

endmodule

// File: rtl/axadd_sum_unit.sv
module axadd_sum_unit #(
    parameter int DATA_W = axadd_pkg::REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic              took_sum,
    input  logic              took_cout,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic              ready
);

    logic seen_sum_q, seen_cout_q;
    logic [DATA_W:0] wide;

    assign wide = {1'b0, opa} + {1'b0, opb};

    always_ff @(posedge clk) begin
        if (rst) begin
            sum         <= '0;
            cout        <= 1'b0;
            ready       <= 1'b0;
            seen_sum_q  <= 1'b0;
            seen_cout_q <= 1'b0;
        end else if (go) begin
            sum         <= wide[DATA_W-1:0];
            cout        <= wide[DATA_W];
            ready       <= 1'b1;
            seen_sum_q  <= 1'b0;
            seen_cout_q <= 1'b0;
        end else if (ready) begin
            if ((seen_sum_q || took_sum) && (seen_cout_q || took_cout)) begin
                ready       <= 1'b0;
                seen_sum_q  <= 1'b0;
                seen_cout_q <= 1'b0;
            end else begin
                seen_sum_q  <= seen_sum_q || took_sum;
                seen_cout_q <= seen_cout_q || took_cout;
            end
        end
    end

endmodule

// File: rtl/axadd_regs.sv
module axadd_regs
    import axadd_pkg::*;
#(
    parameter int ADDR_W = OFS_W,
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_value
);

    localparam int PAD_W = 32 - ADDR_W;

    logic [DATA_W-1:0] opa_q, opb_q, sum;
    logic go_q, cout, ready;
    reg_sel_t wsel, rsel;

    assign wsel = decode_ofs({{PAD_W{1'b0}}, wr_addr});
    assign rsel = decode_ofs({{PAD_W{1'b0}}, rd_addr});

    always_ff @(posedge clk) begin
        if (rst) begin
            opa_q <= '0;
            opb_q <= '0;
            go_q  <= 1'b0;
        end else begin
            go_q <= wr_en && wsel.ctrl && wr_data[CTRL_GO_BIT];
            if (wr_en && wsel.opa) opa_q <= wr_data;
            if (wr_en && wsel.opb) opb_q <= wr_data;
        end
    end

    axadd_sum_unit #(.DATA_W(DATA_W)) sum_i (
        .clk       (clk),
        .rst       (rst),
        .go        (go_q),
        .opa       (opa_q),
        .opb       (opb_q),
        .took_sum  (rd_en && rsel.sum),
        .took_cout (rd_en && rsel.cout),
        .sum       (sum),
        .cout      (cout),
        .ready     (ready)
    );

    always_comb begin
        rd_value = DATA_W'(MISS_VALUE);
        if (rsel.opa)  rd_value = opa_q;
        if (rsel.opb)  rd_value = opb_q;
        if (rsel.sum)  rd_value = sum;
        if (rsel.cout) rd_value = {{(DATA_W-1){1'b0}}, cout};
        if (rsel.ctrl) begin
            rd_value = '0;
            rd_value[CTRL_RDY_BIT] = ready;
        end
    end

endmodule

// File: rtl/axil_adder.sv
module axil_adder
    import axadd_pkg::*;
#(
    parameter int ADDR_W = OFS_W,
    parameter int DATA_W = REG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_wvalid,
    output logic              s_wready,
    input  logic [DATA_W-1:0] s_wdata,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [1:0]        s_bresp,
    input  logic              s_arvalid,
    output logic              s_arready,
    input  logic [ADDR_W-1:0] s_araddr,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp
);

    logic              wr_en, rd_en;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_value;

    axadd_bus_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) fsm_i (
        .clk      (clk),
        .rst      (rst),
        .awvalid  (s_awvalid),
        .awready  (s_awready),
        .awaddr   (s_awaddr),
        .wvalid   (s_wvalid),
        .wready   (s_wready),
        .wdata    (s_wdata),
        .bvalid   (s_bvalid),
        .bready   (s_bready),
        .arvalid  (s_arvalid),
        .arready  (s_arready),
        .araddr   (s_araddr),
        .rvalid   (s_rvalid),
        .rready   (s_rready),
        .rdata    (s_rdata),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_value (rd_value)
    );

    axadd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_value (rd_value)
    );

    assign s_bresp = 2'b00;
    assign s_rresp = 2'b00;

endmodule

// File: rtl/axil_adder_chk.sv
module axil_adder_chk #(
    parameter int DATA_W = axadd_pkg::REG_W
) (
    input logic              clk,
    input logic              rst,
    input logic              awvalid,
    input logic              awready,
    input logic              wvalid,
    input logic              wready,
    input logic              arready,
    input logic              bvalid,
    input logic              bready,
    input logic [1:0]        bresp,
    input logic              rvalid,
    input logic              rready,
    input logic [DATA_W-1:0] rdata,
    input logic [1:0]        rresp
);

    p_bresp_okay_r7: assert property (@(posedge clk) disable iff (rst)
        bvalid |-> bresp == 2'b00);

    p_b_hold_r8: assert property (@(posedge clk) disable iff (rst)
        bvalid && !bready |=> bvalid);

    p_r_hold_r8: assert property (@(posedge clk) disable iff (rst)
        rvalid && !rready |=> rvalid && $stable(rdata));

    p_rresp_okay_r8: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> rresp == 2'b00);

    p_write_first_r9: assert property (@(posedge clk) disable iff (rst)
        (awvalid || wvalid) |-> !arready);

    p_one_reply_r11: assert property (@(posedge clk) disable iff (rst)
        !(bvalid && rvalid));

    p_busy_closed_r11: assert property (@(posedge clk) disable iff (rst)
        (bvalid || rvalid) |-> !awready && !wready && !arready);

endmodule

bind axil_adder axil_adder_chk #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .awvalid (s_awvalid),
    .awready (s_awready),
    .wvalid  (s_wvalid),
    .wready  (s_wready),
    .arready (s_arready),
    .bvalid  (s_bvalid),
    .bready  (s_bready),
    .bresp   (s_bresp),
    .rvalid  (s_rvalid),
    .rready  (s_rready),
    .rdata   (s_rdata),
    .rresp   (s_rresp)
);

// File: tb/axil_adder_tb_top.sv
module axil_adder_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [7:0]  awaddr = '0, araddr = '0;
    logic [31:0] wdata = '0;
    logic awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    axil_adder dut_i (
        .clk(clk), .rst(rst),
        .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
        .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata),
        .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
        .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
        .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp)
    );

    localparam int NVEC = 6;
    localparam logic [63:0] VECS [NVEC] = '{
        {32'h0000_0000, 32'h0000_0000},
        {32'h0000_0001, 32'h0000_0002},
        {32'hFFFF_FFFF, 32'h0000_0001},
        {32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'h8000_0000, 32'h8000_0000},
        {32'h1234_5678, 32'h9ABC_DEF0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d,
                            input int order, input int bdelay);
        bit aw_done = 0, w_done = 0, ah, wh;
        @(negedge clk);
        if (order != 2) begin awvalid = 1; awaddr = a; end
        if (order != 1) begin wvalid = 1; wdata = d; end
        while (!(aw_done && w_done)) begin
            #1;
            ah = awvalid && awready;
            wh = wvalid && wready;
            @(posedge clk);
            @(negedge clk);
            if (ah) begin awvalid = 0; aw_done = 1; end
            if (wh) begin wvalid = 0; w_done = 1; end
            if (aw_done && !w_done && !wvalid) begin wvalid = 1; wdata = d; end
            if (w_done && !aw_done && !awvalid) begin awvalid = 1; awaddr = a; end
        end
        while (!bvalid) @(negedge clk);
        for (int k = 0; k < bdelay; k++) begin
            @(negedge clk);
            check("R8 bvalid held", 32'(bvalid), 32'd1);
            check("R11 readies low in response", 32'({awready, wready, arready}), 32'd0);
        end
        check("R7 bresp", 32'(bresp), 32'd0);
        bready = 1;
        @(posedge clk);
        @(negedge clk);
        bready = 0;
        check("R7 single response", 32'(bvalid), 32'd0);
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d, input int rdelay);
        bit h;
        @(negedge clk);
        arvalid = 1;
        araddr = a;
        forever begin
            #1;
            h = arvalid && arready;
            @(posedge clk);
            @(negedge clk);
            if (h) break;
        end
        arvalid = 0;
        while (!rvalid) @(negedge clk);
        d = rdata;
        for (int k = 0; k < rdelay; k++) begin
            @(negedge clk);
            check("R8 rvalid held", 32'(rvalid), 32'd1);
            check("R8 rdata stable", rdata, d);
        end
        check("R8 rresp", 32'(rresp), 32'd0);
        rready = 1;
        @(posedge clk);
        @(negedge clk);
        rready = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, a, b;
        logic [32:0] w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check("R10 idle readies", 32'({awready, wready, arready}), 32'h7);
        check("R10 no replies", 32'({bvalid, rvalid}), 32'd0);
        do_read(8'h00, v, 0); check("R10 opa reset", v, 0);
        do_read(8'h04, v, 0); check("R10 opb reset", v, 0);
        do_read(8'h08, v, 0); check("R10 sum reset", v, 0);
        do_read(8'h0C, v, 0); check("R10 carry reset", v, 0);
        do_read(8'h10, v, 0); check("R10 ctrl reset", v, 0);

        for (int i = 0; i < NVEC; i++) begin
            a = VECS[i][63:32];
            b = VECS[i][31:0];
            w = {1'b0, a} + {1'b0, b};
            do_write(8'h00, a, i % 3, 0);
            do_write(8'h04, b, (i + 1) % 3, 0);
            do_read(8'h00, v, 0); check("R1 opa readback", v, a);
            do_read(8'h04, v, 0); check("R1 opb readback", v, b);
            do_write(8'h10, 32'h1, i % 3, (i % 2) * 2);
            do_read(8'h10, v, 0); check("R3 ctrl ready, start reads 0", v, 32'h2);
            if (i % 2 == 0) begin
                do_read(8'h08, v, 0); check("R2 sum", v, w[31:0]);
                do_read(8'h10, v, 0); check("R4 still ready after sum", v, 32'h2);
                do_read(8'h0C, v, 0); check("R2 carry", v, {31'b0, w[32]});
            end else begin
                do_read(8'h0C, v, 1); check("R2 carry", v, {31'b0, w[32]});
                do_read(8'h10, v, 0); check("R4 still ready after carry", v, 32'h2);
                do_read(8'h08, v, 0); check("R2 sum", v, w[31:0]);
            end
            do_read(8'h10, v, 0); check("R4 ready cleared", v, 32'h0);
        end

        // R5: writes to result registers and unmapped offsets are dropped
        do_write(8'h08, 32'h5555_AAAA, 0, 0);
        do_write(8'h0C, 32'hFFFF_FFFF, 1, 0);
        do_write(8'h20, 32'h0BAD_0BAD, 2, 0);
        do_write(8'h02, 32'h0BAD_0BAD, 0, 0);
        do_read(8'h08, v, 0); check("R5 sum untouched", v, 32'hACF1_3568);
        do_read(8'h0C, v, 0); check("R5 carry untouched", v, 32'h0);
        do_read(8'h00, v, 0); check("R5 opa untouched", v, 32'h1234_5678);
        do_read(8'h04, v, 0); check("R5 opb untouched", v, 32'h9ABC_DEF0);

        // R6: unmapped and unaligned reads
        do_read(8'h14, v, 0); check("R6 unmapped 0x14", v, 32'hDEAD_BEEF);
        do_read(8'h01, v, 0); check("R6 unaligned 0x01", v, 32'hDEAD_BEEF);
        do_read(8'hFC, v, 3); check("R6 unmapped 0xFC", v, 32'hDEAD_BEEF);

        // R3: control write without start bit does nothing; all-ones writes only start
        do_write(8'h10, 32'hFFFF_FFFE, 0, 0);
        do_read(8'h10, v, 0); check("R3 no start on bit0 clear", v, 32'h0);
        do_write(8'h00, 32'h0000_0010, 0, 0);
        do_write(8'h10, 32'hFFFF_FFFF, 0, 0);
        do_read(8'h10, v, 0); check("R3 ctrl reserved bits zero", v, 32'h2);
        do_read(8'h08, v, 0); check("R2 sum second run", v, 32'h9ABC_DF00);
        do_read(8'h0C, v, 0); check("R4 carry read", v, 32'h0);

        // R9: write and read raised in the same cycle
        @(negedge clk);
        awvalid = 1; awaddr = 8'h04;
        wvalid = 1;  wdata = 32'hCAFE_F00D;
        arvalid = 1; araddr = 8'h04;
        #1;
        check("R9 arready low with write pending", 32'(arready), 32'd0);
        check("R9 write accepted first", 32'({awready, wready}), 32'h3);
        @(posedge clk);
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        bready = 1;
        while (!bvalid) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        bready = 0;
        while (!rvalid) @(negedge clk);
        arvalid = 0;
        check("R9 read sees new value", rdata, 32'hCAFE_F00D);
        rready = 1;
        @(posedge clk);
        @(negedge clk);
        rready = 0;
        check("R8 rvalid drops after rready", 32'(rvalid), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule